// File: doc/BRIEF.md
# Interrupt Request Resolver

This block decides, for a small 8-bit processor, whether an interrupt is to be serviced once the current instruction ends. It watches three request lines. The non-maskable request is edge-triggered: a low-to-high change on that line arms a pending flag, and the flag stays set until the vector stage uses it. The external and audio maskable requests are plain levels. The block reads them as they are and never latches them.

On the clock in which the sequencer flags the final cycle of an instruction, the block records one take-interrupt decision. The decision is taken when the pending non-maskable flag is set, or when either maskable level is high and the processor's interrupt-disable flag is clear. Between final-cycle strobes the recorded decision holds its value.

When the sequencer asks for a vector, it offers the address it plans to use. If the non-maskable flag is pending, the block replaces that address with the fixed non-maskable vector and clears the flag. If the flag is not pending, the offered address passes through unchanged.

Top module: `intr_resolver`

## Requirements
- R1: Reset clears the non-maskable pending flag (`nmi_pending`) and the recorded decision (`take_intr` = 0). Reset also clears the stored previous level of `nmi_req`.
- R2: A clock edge at which `nmi_req` is 1 and was 0 at the previous edge sets `nmi_pending`. The flag reads 1 right after that edge.
- R3: Holding `nmi_req` high after a clear does not set `nmi_pending` again. A new 0-to-1 transition is needed.
- R4: At an edge where `last_cycle` is 1, `take_intr` is loaded with ((`ext_irq` OR `snd_irq`) AND NOT `irq_mask`) OR `nmi_pending`. The inputs used are the values present at that edge.
- R5: At an edge where `last_cycle` is 0, `take_intr` keeps its value whatever the request lines and `irq_mask` do.
- R6: While `vec_req` is 1 and `nmi_pending` is 1, `vec_out` is 16'hFFFA. The edge that ends that cycle clears `nmi_pending`.
- R7: While `vec_req` is 0 or `nmi_pending` is 0, `vec_out` equals `vec_in`.
- R8: If a rising edge of `nmi_req` arrives at the same edge as a clear from `vec_req`, `nmi_pending` is 1 after that edge. The set wins.
- R9: The maskable lines are not latched. A pulse on `ext_irq` that falls before the final-cycle strobe leaves `take_intr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request line, acted on at its rising edge |
| ext_irq | input | 1 | External maskable request, level |
| snd_irq | input | 1 | Audio-unit maskable request, level |
| irq_mask | input | 1 | Processor interrupt-disable flag |
| last_cycle | input | 1 | Strobe marking the final cycle of an instruction |
| vec_req | input | 1 | Vector request from the sequencer |
| vec_in | input | 16 | Vector address offered by the sequencer |
| vec_out | output | 16 | Vector address to use |
| nmi_pending | output | 1 | Non-maskable pending flag |
| take_intr | output | 1 | Recorded take-interrupt decision |

## Verification
The bench sweeps all sixteen combinations of the two maskable levels, the disable flag and the pending flag through a final-cycle strobe. It then flips every input with the strobe low to show the decision holds. A design that samples every cycle, or that forgets the disable flag, would miss those values.

Other checks target the edge detector:
- A line held high after a clear must not re-arm the flag. A level-triggered design would service the non-maskable request again and again.
- A rising edge arriving in the same cycle as a clear must leave the flag set. A design that gives the clear priority would drop that request.

A short pulse on a maskable line that ends before the strobe shows the levels are not latched.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] NMI_VECTOR = 16'hFFFA;

  // Interrupt decision: any unmasked level request, or a pending NMI.
  function automatic logic want_intr(input logic [1:0] lvl, input logic mask,
                                     input logic nmi);
    return ((|lvl) & ~mask) | nmi;
  endfunction

  // Vector substitution for a pending NMI.
  function automatic logic [VEC_W-1:0] pick_vec(input logic use_nmi,
                                                input logic [VEC_W-1:0] given);
    return use_nmi ? NMI_VECTOR : given;
  endfunction
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic clr,
  output logic rise,
  output logic pending
);
  logic prev_q;

  assign rise = line & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev_q <= line;
      if (rise)
        pending <= 1'b1;
      else if (clr)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_sample_reg.sv
module intr_sample_reg #(
  parameter int LVL_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [LVL_N-1:0] lvl,
  input  logic             mask,
  input  logic             nmi,
  output logic             taken
);
  logic decide;

  assign decide = intr_pkg::want_intr(lvl, mask, nmi);

  always_ff @(posedge clk) begin
    if (!rst_n)
      taken <= 1'b0;
    else if (strobe)
      taken <= decide;
  end
endmodule

// File: rtl/vec_mux.sv
module vec_mux (
  input  logic                        use_nmi,
  input  logic [intr_pkg::VEC_W-1:0]  given,
  output logic [intr_pkg::VEC_W-1:0]  chosen
);
  assign chosen = intr_pkg::pick_vec(use_nmi, given);
endmodule

// File: rtl/intr_resolver.sv
module intr_resolver (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        ext_irq,
  input  logic        snd_irq,
  input  logic        irq_mask,
  input  logic        last_cycle,
  input  logic        vec_req,
  input  logic [15:0] vec_in,
  output logic [15:0] vec_out,
  output logic        nmi_pending,
  output logic        take_intr
);
  localparam int LVL_N = 2;

  logic             nmi_rise;
  logic             nmi_use;
  logic [LVL_N-1:0] lvl_bus;

  assign lvl_bus = {snd_irq, ext_irq};
  assign nmi_use = vec_req & nmi_pending;

  nmi_edge_latch u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line    (nmi_req),
    .clr     (nmi_use),
    .rise    (nmi_rise),
    .pending (nmi_pending)
  );

  intr_sample_reg #(.LVL_N(LVL_N)) u_sample (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (last_cycle),
    .lvl    (lvl_bus),
    .mask   (irq_mask),
    .nmi    (nmi_pending),
    .taken  (take_intr)
  );

  vec_mux u_vec (
    .use_nmi (nmi_use),
    .given   (vec_in),
    .chosen  (vec_out)
  );
endmodule

// File: rtl/intr_resolver_chk.sv
module intr_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_rise,
  input logic        nmi_pending,
  input logic        ext_irq,
  input logic        snd_irq,
  input logic        irq_mask,
  input logic        last_cycle,
  input logic        vec_req,
  input logic [15:0] vec_in,
  input logic [15:0] vec_out,
  input logic        take_intr
);
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmi_pending);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_rise && !nmi_pending) |=> !nmi_pending);

  p_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_cycle |=> take_intr ==
      ((($past(ext_irq) | $past(snd_irq)) & ~$past(irq_mask)) | $past(nmi_pending)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !last_cycle |=> $stable(take_intr));

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && nmi_pending) |-> vec_out == 16'hFFFA);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && nmi_pending && !nmi_rise) |=> !nmi_pending);

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_req && nmi_pending) |-> vec_out == vec_in);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_rise && vec_req) |=> nmi_pending);
endmodule

bind intr_resolver intr_resolver_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_rise    (nmi_rise),
  .nmi_pending (nmi_pending),
  .ext_irq     (ext_irq),
  .snd_irq     (snd_irq),
  .irq_mask    (irq_mask),
  .last_cycle  (last_cycle),
  .vec_req     (vec_req),
  .vec_in      (vec_in),
  .vec_out     (vec_out),
  .take_intr   (take_intr)
);

// File: tb/intr_resolver_test.sv
`timescale 1ns/1ps
module intr_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0, ext_irq = 1'b0, snd_irq = 1'b0, irq_mask = 1'b0;
  logic        last_cycle = 1'b0, vec_req = 1'b0;
  logic [15:0] vec_in = 16'h0000;
  logic [15:0] vec_out;
  logic        nmi_pending, take_intr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intr_resolver uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .ext_irq(ext_irq),
    .snd_irq(snd_irq), .irq_mask(irq_mask), .last_cycle(last_cycle),
    .vec_req(vec_req), .vec_in(vec_in), .vec_out(vec_out),
    .nmi_pending(nmi_pending), .take_intr(take_intr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(); tick(); tick();
    chk("R1 pending", {15'd0, nmi_pending}, 16'd0);
    chk("R1 take", {15'd0, take_intr}, 16'd0);
    rst_n = 1'b1;
    tick();

    // R2: rising edge sets the flag
    chk("R2 before", {15'd0, nmi_pending}, 16'd0);
    nmi_req = 1'b1;
    tick();
    chk("R2 set", {15'd0, nmi_pending}, 16'd1);

    // R6: vector substitution and clear
    vec_in = 16'h1234; vec_req = 1'b1;
    #1 chk("R6 vector", vec_out, 16'hFFFA);
    tick();
    vec_req = 1'b0;
    chk("R6 clear", {15'd0, nmi_pending}, 16'd0);

    // R3: held-high line must not re-arm
    tick(); tick(); tick();
    chk("R3 held", {15'd0, nmi_pending}, 16'd0);
    vec_in = 16'hABCD; vec_req = 1'b1;
    #1 chk("R7 no pending", vec_out, 16'hABCD);
    tick();
    vec_req = 1'b0;

    // R8: set wins over clear
    nmi_req = 1'b0; tick();
    nmi_req = 1'b1; tick();
    nmi_req = 1'b0; tick();
    chk("R8 armed", {15'd0, nmi_pending}, 16'd1);
    nmi_req = 1'b1; vec_req = 1'b1;
    tick();
    vec_req = 1'b0;
    chk("R8 set wins", {15'd0, nmi_pending}, 16'd1);
    vec_req = 1'b1; tick(); vec_req = 1'b0;
    chk("R6 clear2", {15'd0, nmi_pending}, 16'd0);
    nmi_req = 1'b0; tick();

    // R4/R5: exhaustive sweep of decision inputs
    for (int k = 0; k < 16; k++) begin
      logic p, e, s, d, expv;
      {p, e, s, d} = k[3:0];
      if (p) begin
        nmi_req = 1'b1; tick(); nmi_req = 1'b0; tick();
      end
      ext_irq = e; snd_irq = s; irq_mask = d; last_cycle = 1'b1;
      tick();
      last_cycle = 1'b0;
      expv = ((e | s) & ~d) | p;
      chk("R4 sample", {15'd0, take_intr}, {15'd0, expv});
      ext_irq = ~e; snd_irq = ~s; irq_mask = ~d;
      nmi_req = 1'b1;
      tick(); tick();
      chk("R5 hold", {15'd0, take_intr}, {15'd0, expv});
      nmi_req = 1'b0;
      vec_req = 1'b1; tick(); vec_req = 1'b0; tick();
      ext_irq = 1'b0; snd_irq = 1'b0; irq_mask = 1'b0;
    end
    chk("R6 swept clear", {15'd0, nmi_pending}, 16'd0);

    // R9: pulse that ends before the strobe is not latched
    ext_irq = 1'b1; tick(); ext_irq = 1'b0;
    snd_irq = 1'b1; tick(); snd_irq = 1'b0;
    last_cycle = 1'b1; tick(); last_cycle = 1'b0;
    chk("R9 no latch", {15'd0, take_intr}, 16'd0);

    // R7: passthrough sweep
    for (int i = 0; i < 32; i++) begin
      vec_in = 16'(i * 2053 + 7);
      vec_req = i[0];
      #1 chk("R7 pass", vec_out, 16'(i * 2053 + 7));
      tick();
    end
    vec_req = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule